// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Sensing

This block controls a 32-pin general-purpose I/O port behind a small synchronous register bus. Software sets the value each pin drives and whether the pin drives at all. It can read the synchronized level of every pad, whatever the pin's direction.

Each pin can raise an interrupt on one of four conditions, chosen by a 2-bit code:

| Code | Condition |
|------|-----------|
| 0 | low level |
| 1 | high level |
| 2 | rising edge |
| 3 | falling edge |

A hit sets the pin's pending bit. Software clears a pending bit by writing a one to it. A per-pin enable decides which pending bits may drive the single interrupt request line.

The bus works as follows:
- The bus uses byte addresses.
- A write takes effect on the clock edge where the write enable is high.
- A read returns data on the output one cycle after the read enable is sampled.

The register offsets are:

| Offset | Register |
|--------|----------|
| 0x00 | drive data |
| 0x04 | direction |
| 0x08 | pad level (read only) |
| 0x0C | sense codes for pins 0–15 |
| 0x10 | sense codes for pins 16–31 |
| 0x14 | enable |
| 0x18 | pending |

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low and after its release, `gpio_out`, `gpio_oe` and `irq` are 0. The drive-data, direction, sense-code and enable registers read back as 0.
- R2: A write to offset 0x00 or 0x04 shows on `gpio_out` or `gpio_oe` in the cycle after the write edge, and the value reads back unchanged. A direction bit of 1 means the pin drives.
- R3: Offset 0x08 returns `pad_in` delayed by a two-flop synchronizer, for every pin whatever its direction. Writes to offset 0x08 change nothing.
- R4: Pin n's 2-bit sense code sits at bits [2*(n mod 16)+1 : 2*(n mod 16)]. It lives at offset 0x0C for n < 16 and at offset 0x10 for n ≥ 16. Both registers read back as written.
- R5: With code 2, a 0-to-1 change of the synchronized pad sets the pin's pending bit once. Once cleared, the bit stays clear while the pad stays high.
- R6: With code 3, a 1-to-0 change of the synchronized pad sets the pin's pending bit once. The earlier high level sets nothing.
- R7: With code 0 (low) or code 1 (high), the pending bit is set again on every cycle the selected level is present. A clear therefore only sticks once the level has gone away.
- R8: Writing offset 0x18 clears each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R9: `irq` is high exactly when some pin has both its pending bit and its enable bit (offset 0x14) set. A pending bit is recorded even while its pin is disabled.
- R10: If a set condition and a write-1 clear hit the same pending bit on the same edge, the bit ends up set.
- R11: Read data appears on `reg_rdata` the cycle after `reg_re` is sampled. Addresses outside the seven registers read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Byte address of register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read enable |
| reg_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| gpio_out | output | 32 | Output drive values |
| gpio_oe | output | 32 | Output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The timing of each result is as follows:
- A pad change reaches the pad-level register two edges after it is driven.
- An edge or level hit lands in the pending register on the third edge, and `irq` follows in the same cycle.
- Data, direction and enable writes show on the outputs the cycle after their write edge.
- A read returns its value one edge after `reg_re`.

The bench drives inputs on falling edges and counts exactly those edges before it samples, on a falling edge. The set-wins case places the clear write on the third edge after the pad change, so that it coincides with the detected edge.

// File: rtl/gpio_pkg.sv
// Shared constants and types for the GPIO port.
// Assumes byte addressing with 32-bit word registers.
package gpio_pkg;

    localparam int unsigned GP_ADDR_W = 5;
    localparam int unsigned GP_DATA_W = 32;

    localparam logic [GP_ADDR_W-1:0] OFS_DATA = 5'h00;
    localparam logic [GP_ADDR_W-1:0] OFS_DIR  = 5'h04;
    localparam logic [GP_ADDR_W-1:0] OFS_PAD  = 5'h08;
    localparam logic [GP_ADDR_W-1:0] OFS_CFGL = 5'h0C;
    localparam logic [GP_ADDR_W-1:0] OFS_CFGH = 5'h10;
    localparam logic [GP_ADDR_W-1:0] OFS_EN   = 5'h14;
    localparam logic [GP_ADDR_W-1:0] OFS_PEND = 5'h18;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_HIGH = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_FALL = 2'd3
    } sense_e;

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for the pad inputs.
// Assumes each bit is independent; no bus coherence is needed.
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Purpose: shift pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_sense.sv
// Per-pin interrupt condition detector.
// Produces a one-cycle set request per pin from the synchronized level,
// its value one cycle earlier and the pin's 2-bit sense code.
// Assumes 'level' is already synchronous to clk.
module gpio_sense
    import gpio_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   level,
    input  logic [2*PINS-1:0] codes,
    output logic [PINS-1:0]   set_ev
);

    logic [PINS-1:0] prev_q;

    // Purpose: remember last cycle's synchronized level for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        sense_e code;
        assign code = sense_e'(codes[2*i +: 2]);

        // Purpose: decode the sense code into this pin's set request.
        always_comb begin
            unique case (code)
                SENSE_LOW:  set_ev[i] = ~level[i];
                SENSE_HIGH: set_ev[i] =  level[i];
                SENSE_RISE: set_ev[i] =  level[i] & ~prev_q[i];
                SENSE_FALL: set_ev[i] = ~level[i] &  prev_q[i];
                default:    set_ev[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pending.sv
// Pending-interrupt register with write-one-to-clear.
// A set request on the same edge as a clear keeps the bit set.
module gpio_pending #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] set_ev,
    input  logic            clr_we,
    input  logic [PINS-1:0] clr_mask,
    output logic [PINS-1:0] pend_q
);

    logic [PINS-1:0] clr_bits;

    // Purpose: select which bits a clear write removes this cycle.
    always_comb begin
        clr_bits = clr_we ? clr_mask : '0;
    end

    // Purpose: hold pending bits; set requests override clears.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_bits) | set_ev;
    end

endmodule

// File: rtl/gpio_port.sv
// GPIO port top: register file, bus decode, registered read path,
// pad synchronization, interrupt sensing and request combining.
// Assumes byte addresses on word boundaries; sub-word offsets are unmapped.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = GP_ADDR_W,
    parameter int unsigned DATA_W = GP_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] gpio_out,
    output logic [DATA_W-1:0] gpio_oe,
    output logic              irq
);

    localparam int unsigned PINS     = DATA_W;
    localparam int unsigned CFG_BITS = 2 * PINS;

    logic [DATA_W-1:0]   data_q;
    logic [DATA_W-1:0]   dir_q;
    logic [DATA_W-1:0]   en_q;
    logic [CFG_BITS-1:0] cfg_q;
    logic [DATA_W-1:0]   rdata_q;
    logic [PINS-1:0]     pad_sync;
    logic [PINS-1:0]     set_ev;
    logic [PINS-1:0]     status_q;
    logic                pend_clr;
    logic [DATA_W-1:0]   rd_mux;

    // Purpose: flag a write to the pending register.
    always_comb begin
        pend_clr = reg_we && (reg_addr == OFS_PEND);
    end

    // Purpose: update the writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            en_q   <= '0;
            cfg_q  <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                OFS_DATA: data_q <= reg_wdata;
                OFS_DIR:  dir_q  <= reg_wdata;
                OFS_EN:   en_q   <= reg_wdata;
                OFS_CFGL: cfg_q[DATA_W-1:0]        <= reg_wdata;
                OFS_CFGH: cfg_q[CFG_BITS-1:DATA_W] <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Purpose: select read data by address; unmapped reads return 0.
    always_comb begin
        unique case (reg_addr)
            OFS_DATA: rd_mux = data_q;
            OFS_DIR:  rd_mux = dir_q;
            OFS_PAD:  rd_mux = pad_sync;
            OFS_CFGL: rd_mux = cfg_q[DATA_W-1:0];
            OFS_CFGH: rd_mux = cfg_q[CFG_BITS-1:DATA_W];
            OFS_EN:   rd_mux = en_q;
            OFS_PEND: rd_mux = status_q;
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_re) rdata_q <= rd_mux;
    end

    gpio_sync #(.WIDTH(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_sense #(.PINS(PINS)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (pad_sync),
        .codes  (cfg_q),
        .set_ev (set_ev)
    );

    gpio_pending #(.PINS(PINS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set_ev),
        .clr_we   (pend_clr),
        .clr_mask (reg_wdata),
        .pend_q   (status_q)
    );

    assign reg_rdata = rdata_q;
    assign gpio_out  = data_q;
    assign gpio_oe   = dir_q;
    assign irq       = |(status_q & en_q);

endmodule

// File: rtl/gpio_port_chk.sv
// Assertion checker for gpio_port, attached by bind.
// Assumes synchronous active-low reset; $past checks wait one cycle after reset.
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = GP_ADDR_W,
    parameter int unsigned DATA_W = GP_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_we,
    input logic [DATA_W-1:0] gpio_out,
    input logic [DATA_W-1:0] gpio_oe,
    input logic              irq,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] set_ev
);

    logic past_ok;

    // Purpose: mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_out_write: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (reg_we && reg_addr == OFS_DATA) |=> (gpio_out == $past(reg_wdata)));

    a_r2_oe_write: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (reg_we && reg_addr == OFS_DIR) |=> (gpio_oe == $past(reg_wdata)));

    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (reg_we && reg_addr == OFS_PEND) |=>
            ((status_q & $past(reg_wdata) & ~$past(set_ev)) == '0));

    a_r10_set_kept: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (($past(set_ev) & ~status_q) == '0));

    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ((status_q & ~$past(status_q) & ~$past(set_ev)) == '0));

    a_r9_disable_all: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (reg_we && reg_addr == OFS_EN && reg_wdata == '0) |=> !irq);

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (gpio_out == '0 && gpio_oe == '0 && !irq));

endmodule

bind gpio_port gpio_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .gpio_out  (gpio_out),
    .gpio_oe   (gpio_oe),
    .irq       (irq),
    .status_q  (status_q),
    .set_ev    (set_ev)
);

// File: tb/sim_gpio_port.sv
// Self-checking bench: sweeps every pin with every sense code.
module sim_gpio_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] gpio_out;
    logic [31:0] gpio_oe;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .gpio_out  (gpio_out),
        .gpio_oe   (gpio_oe),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a; reg_re = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [63:0] cfg_with(input int pin, input logic [1:0] code);
        logic [63:0] v;
        v = {32{2'b10}};
        v[2*pin +: 2] = code;
        return v;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] rd;
        logic [63:0] cfg;
        logic [31:0] bitp;

        repeat (3) @(negedge clk);
        check("R1 out in reset", gpio_out, 32'h0);
        check("R1 oe in reset", gpio_oe, 32'h0);
        check("R1 irq in reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(5'h00, rd); check("R1 data reg", rd, 32'h0);
        bus_read(5'h04, rd); check("R1 dir reg", rd, 32'h0);
        bus_read(5'h0C, rd); check("R1 cfg low", rd, 32'h0);
        bus_read(5'h10, rd); check("R1 cfg high", rd, 32'h0);
        bus_read(5'h14, rd); check("R1 enable", rd, 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);

        // R2 drive data and direction
        bus_write(5'h00, 32'hA5A5_0F0F);
        check("R2 gpio_out", gpio_out, 32'hA5A5_0F0F);
        bus_write(5'h04, 32'hFFFF_0000);
        check("R2 gpio_oe", gpio_oe, 32'hFFFF_0000);
        bus_read(5'h00, rd); check("R2 data readback", rd, 32'hA5A5_0F0F);
        bus_read(5'h04, rd); check("R2 dir readback", rd, 32'hFFFF_0000);

        // R3 pad level via synchronizer, independent of direction
        pad_in = 32'h1234_5678;
        @(posedge clk);
        bus_read(5'h08, rd); check("R3 pad one edge late", rd, 32'h0);
        bus_read(5'h08, rd); check("R3 pad level", rd, 32'h1234_5678);
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_read(5'h08, rd); check("R3 pad write ignored", rd, 32'h1234_5678);
        bus_read(5'h00, rd); check("R3 data unchanged", rd, 32'hA5A5_0F0F);
        pad_in = '0;
        wait_edges(3);

        // R11 unmapped address and registered timing
        bus_read(5'h1C, rd); check("R11 unmapped reads zero", rd, 32'h0);
        bus_read(5'h02, rd); check("R11 misaligned reads zero", rd, 32'h0);

        // R4 configuration readback
        bus_write(5'h0C, 32'h1B1B_1B1B);
        bus_write(5'h10, 32'hE4E4_E4E4);
        bus_read(5'h0C, rd); check("R4 cfg low readback", rd, 32'h1B1B_1B1B);
        bus_read(5'h10, rd); check("R4 cfg high readback", rd, 32'hE4E4_E4E4);

        // Sweep: every pin, every sense code (R4..R9)
        for (int p = 0; p < 32; p++) begin
            for (int c = 0; c < 4; c++) begin
                bitp = 32'h1 << p;
                cfg = cfg_with(p, c[1:0]);
                bus_write(5'h0C, cfg[31:0]);
                bus_write(5'h10, cfg[63:32]);
                bus_write(5'h14, bitp);
                bus_write(5'h18, 32'hFFFF_FFFF);
                case (c)
                    2: begin
                        pad_in = bitp; wait_edges(3);
                        check($sformatf("R5 rise irq pin %0d", p), {31'h0, irq}, 32'h1);
                        bus_read(5'h18, rd); check($sformatf("R5 R4 rise pend pin %0d", p), rd, bitp);
                        bus_write(5'h18, bitp);
                        bus_read(5'h18, rd); check($sformatf("R5 rise once pin %0d", p), rd, 32'h0);
                        check($sformatf("R9 irq low pin %0d", p), {31'h0, irq}, 32'h0);
                    end
                    3: begin
                        pad_in = bitp; wait_edges(3);
                        bus_read(5'h18, rd); check($sformatf("R6 no set on high pin %0d", p), rd, 32'h0);
                        pad_in = '0; wait_edges(3);
                        bus_read(5'h18, rd); check($sformatf("R6 R4 fall pend pin %0d", p), rd, bitp);
                        check($sformatf("R9 fall irq pin %0d", p), {31'h0, irq}, 32'h1);
                    end
                    1: begin
                        pad_in = bitp; wait_edges(3);
                        bus_read(5'h18, rd); check($sformatf("R7 R4 high pend pin %0d", p), rd, bitp);
                        bus_write(5'h18, 32'hFFFF_FFFF);
                        bus_read(5'h18, rd); check($sformatf("R7 high clear blocked pin %0d", p), rd, bitp);
                        pad_in = '0; wait_edges(3);
                        bus_write(5'h18, bitp);
                        bus_read(5'h18, rd); check($sformatf("R7 high clear sticks pin %0d", p), rd, 32'h0);
                    end
                    default: begin
                        wait_edges(1);
                        bus_read(5'h18, rd); check($sformatf("R7 R4 low pend pin %0d", p), rd, bitp);
                        check($sformatf("R9 low irq pin %0d", p), {31'h0, irq}, 32'h1);
                        bus_write(5'h18, bitp);
                        bus_read(5'h18, rd); check($sformatf("R7 low clear blocked pin %0d", p), rd, bitp);
                        pad_in = bitp; wait_edges(3);
                        bus_write(5'h18, bitp);
                        bus_read(5'h18, rd); check($sformatf("R7 low clear sticks pin %0d", p), rd, 32'h0);
                    end
                endcase
                pad_in = '0;
                wait_edges(4);
            end
        end

        // R8 write-zero leaves bits, write-one clears selected bits
        bus_write(5'h0C, 32'hAAAA_AAAA);
        bus_write(5'h10, 32'hAAAA_AAAA);
        bus_write(5'h14, 32'h0);
        bus_write(5'h18, 32'hFFFF_FFFF);
        pad_in = 32'h8000_0101; wait_edges(3);
        bus_write(5'h18, 32'h0);
        bus_read(5'h18, rd); check("R8 write zero keeps", rd, 32'h8000_0101);
        check("R9 disabled pending no irq", {31'h0, irq}, 32'h0);
        bus_write(5'h18, 32'h0000_0100);
        bus_read(5'h18, rd); check("R8 partial clear", rd, 32'h8000_0001);
        bus_write(5'h14, 32'h0000_0100);
        check("R9 enabled bit not pending", {31'h0, irq}, 32'h0);
        bus_write(5'h14, 32'h8000_0000);
        check("R9 enabled pending irq", {31'h0, irq}, 32'h1);
        bus_write(5'h18, 32'hFFFF_FFFF);
        check("R8 clear all drops irq", {31'h0, irq}, 32'h0);
        pad_in = '0; wait_edges(3);

        // R10 set and clear on the same edge
        bus_write(5'h18, 32'hFFFF_FFFF);
        pad_in = 32'h0000_0004;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_write(5'h18, 32'h0000_0004);
        bus_read(5'h18, rd); check("R10 set wins over clear", rd, 32'h0000_0004);
        pad_in = '0; wait_edges(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule